// File: doc/BRIEF.md
# Shared Exclusive-Access Reservation Monitor

This block arbitrates the exclusive-access bookkeeping of several processor ports that share one memory. Each port owns one reservation entry. An entry is either open, or exclusive on a tag, which is the request address with the bits below the reservation granule forced to zero. Each cycle at most one request is accepted. When several ports request at once, the lowest port index wins, and a waiting port keeps its request up until it is granted.

A request is a read, a load-exclusive, a plain store or a store-exclusive. A load-exclusive reserves the granule for its port. A plain store from any port tears down every reservation on the granule it writes. A store-exclusive gets a pass or fail verdict that tells the memory side whether the write may go ahead. A passing store-exclusive also breaks the reservations that other ports hold on the same granule.

Each port also has a detach level. While it is high, that port's entry is held open.

Top module: `excl_monitor`

## Requirements
- R1: After reset every entry is open with a zero tag, and no grant or response is active. A store-exclusive to address 0 from any port then fails.
- R2: A load-exclusive (op code 1) makes the requester's entry exclusive on its address with the low GRANULE_LSB bits cleared. Any address in the same 8-byte granule then matches it.
- R3: A plain store (op code 2) from any port, the requester included, turns every exclusive entry whose tag equals the masked store address back to open. Entries on other tags keep their state.
- R4: A store-exclusive (op code 3) passes only when the requester's entry is exclusive, its tag matches the masked address and its detach is low. After a pass the requester's entry is open.
- R5: A passing store-exclusive turns open every other port's entry that is exclusive on the same tag. Entries on other tags are kept.
- R6: A store-exclusive from a port whose entry is open fails and changes no entry.
- R7: A store-exclusive from a port that is exclusive on a different tag fails and changes no entry, the requester's included.
- R8: While a port's detach input is high, its entry is open. A load-exclusive from that port reserves nothing, and a store-exclusive from it fails.
- R9: `reqGrant` is one-hot or zero. It grants the lowest-indexed port with `reqValid` high, and it is nonzero whenever any request is present.
- R10: `respValid` pulses for the granted port exactly one cycle after the grant, for every op code. `respPass` is high only for a passing store-exclusive. A read (op code 0) changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Per-port request present, held until granted |
| reqOp | input | 2*NUM_PORTS | Per-port op code: 0 read, 1 load-exclusive, 2 store, 3 store-exclusive |
| reqAddr | input | ADDR_W*NUM_PORTS | Per-port byte address |
| detach | input | NUM_PORTS | Per-port level; holds the entry open and out of monitoring |
| reqGrant | output | NUM_PORTS | Combinational one-hot grant of this cycle's accepted request |
| respValid | output | NUM_PORTS | Response strobe, one cycle after the grant |
| respPass | output | NUM_PORTS | Store-exclusive verdict, qualified by respValid |

## Verification
`reqGrant` is a combinational function of the current requests, so the bench reads it one time step after driving inputs on the falling edge. The verdict and its strobe are registered on the edge that accepts the request. The bench therefore checks them at the next falling edge, one cycle after the grant, and only then drops the request. Entry state is never read directly. Later store-exclusives expose it instead: each one's verdict shows whether an earlier load, store, detach or failed store-exclusive left a reservation in place.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_LDEX  = 2'd1,
    OP_STORE = 2'd2,
    OP_STEX  = 2'd3
  } monOp_e;

  // Strobes from the control to the datapath for the accepted request
  typedef struct packed {
    logic valid;
    logic ldEx;
    logic store;
    logic stEx;
  } monStb_t;

endpackage

// File: rtl/excl_monitor_ctrl.sv
module excl_monitor_ctrl
  import excl_monitor_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PORTS-1:0]   reqValid,
  input  logic [2*NUM_PORTS-1:0] reqOp,
  output logic [NUM_PORTS-1:0]   grant,
  output monStb_t                stb
);

  logic [1:0] opSel;
  monOp_e     opKind;

  // Fixed priority: isolate the lowest set request bit
  assign grant = reqValid & (~reqValid + 1'b1);

  always_comb begin
    opSel = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (grant[i]) opSel = opSel | reqOp[2*i +: 2];
    end
  end

  assign opKind    = monOp_e'(opSel);
  assign stb.valid = |reqValid;
  assign stb.ldEx  = stb.valid && (opKind == OP_LDEX);
  assign stb.store = stb.valid && (opKind == OP_STORE);
  assign stb.stEx  = stb.valid && (opKind == OP_STEX);

  a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  a_r9_grant_when_requested: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid != '0) |-> (grant != '0));

  for (genvar i = 1; i < NUM_PORTS; i++) begin : g_prio
    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rstN)
      grant[i] |-> (reqValid[i-1:0] == '0));
  end

endmodule

// File: rtl/excl_monitor_dp.sv
module excl_monitor_dp
  import excl_monitor_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int ADDR_W      = 32,
  parameter int GRANULE_LSB = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  monStb_t                     stb,
  input  logic [NUM_PORTS-1:0]        grant,
  input  logic [ADDR_W*NUM_PORTS-1:0] reqAddr,
  input  logic [NUM_PORTS-1:0]        detach,
  output logic [NUM_PORTS-1:0]        respValid,
  output logic [NUM_PORTS-1:0]        respPass
);

  localparam logic [ADDR_W-1:0] TAG_MASK = ~((ADDR_W'(1) << GRANULE_LSB) - 1'b1);

  logic [NUM_PORTS-1:0] exclQ;
  logic [ADDR_W-1:0]    tagQ [NUM_PORTS];
  logic [NUM_PORTS-1:0] tagHit;
  logic [ADDR_W-1:0]    selAddr;
  logic [ADDR_W-1:0]    maskedAddr;
  logic                 passNow;

  always_comb begin
    selAddr = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (grant[i]) selAddr = selAddr | reqAddr[ADDR_W*i +: ADDR_W];
    end
  end

  assign maskedAddr = selAddr & TAG_MASK;

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) tagHit[i] = (tagQ[i] == maskedAddr);
  end

  assign passNow = stb.stEx && ((grant & exclQ & tagHit & ~detach) != '0);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        exclQ[i] <= 1'b0;
        tagQ[i]  <= '0;
      end else if (detach[i]) begin
        exclQ[i] <= 1'b0;
        tagQ[i]  <= '0;
      end else if (stb.ldEx && grant[i]) begin
        exclQ[i] <= 1'b1;
        tagQ[i]  <= maskedAddr;
      end else if ((stb.store || passNow) && exclQ[i] && tagHit[i]) begin
        exclQ[i] <= 1'b0;
        tagQ[i]  <= '0;
      end
    end

    a_r8_detach_opens: assert property (@(posedge clk) disable iff (!rstN)
      detach[i] |=> !exclQ[i]);

    a_r4_pass_releases: assert property (@(posedge clk) disable iff (!rstN)
      respPass[i] |-> (!exclQ[i] && respValid[i]));

    a_r4_pass_had_reservation: assert property (@(posedge clk) disable iff (!rstN)
      respPass[i] |-> ($past(exclQ[i]) && ($past(tagQ[i]) == $past(maskedAddr))));

    a_r10_resp_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
      (stb.valid && grant[i]) |=> respValid[i]);
  end

  a_r7_fail_keeps_entries: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stEx && !passNow && (detach == '0)) |=> (exclQ == $past(exclQ)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= '0;
      respPass  <= '0;
    end else begin
      respValid <= stb.valid ? grant : '0;
      respPass  <= passNow ? grant : '0;
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_monitor_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int ADDR_W      = 32,
  parameter int GRANULE_LSB = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [2*NUM_PORTS-1:0]      reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0] reqAddr,
  input  logic [NUM_PORTS-1:0]        detach,
  output logic [NUM_PORTS-1:0]        reqGrant,
  output logic [NUM_PORTS-1:0]        respValid,
  output logic [NUM_PORTS-1:0]        respPass
);

  monStb_t stb;

  excl_monitor_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .grant    (reqGrant),
    .stb      (stb)
  );

  excl_monitor_dp #(
    .NUM_PORTS   (NUM_PORTS),
    .ADDR_W      (ADDR_W),
    .GRANULE_LSB (GRANULE_LSB)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .grant     (reqGrant),
    .reqAddr   (reqAddr),
    .detach    (detach),
    .respValid (respValid),
    .respPass  (respPass)
  );

endmodule

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;

  localparam int NP = 4;
  localparam int AW = 32;
  localparam logic [AW-1:0] MASK = 32'hFFFF_FFF8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NP-1:0]   reqValid = '0;
  logic [2*NP-1:0] reqOp = '0;
  logic [AW*NP-1:0] reqAddr = '0;
  logic [NP-1:0]   detach = '0;
  logic [NP-1:0]   reqGrant, respValid, respPass;

  int total = 0;
  int bad = 0;

  // Reference model of the entries, built from the requirements
  logic          mEx  [NP];
  logic [AW-1:0] mTag [NP];
  logic          mDet [NP];

  always #2 clk = ~clk;

  excl_monitor u_excl_monitor (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .detach(detach), .reqGrant(reqGrant),
    .respValid(respValid), .respPass(respPass)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One isolated request; returns the verdict the model predicted
  task automatic doOp(input int p, input int op, input logic [AW-1:0] a, input string req);
    logic [AW-1:0] t;
    logic expPass;
    t = a & MASK;
    expPass = (op == 3) && mEx[p] && (mTag[p] == t) && !mDet[p];
    @(negedge clk);
    reqAddr[AW*p +: AW] = a;
    reqOp[2*p +: 2] = op[1:0];
    reqValid = '0;
    reqValid[p] = 1'b1;
    #1;
    chk(reqGrant == NP'(1 << p), "R9", 32'(reqGrant), 32'(1 << p));
    // model update
    if (op == 1 && !mDet[p]) begin
      mEx[p] = 1'b1; mTag[p] = t;
    end else if (op == 2 || (op == 3 && expPass)) begin
      for (int i = 0; i < NP; i++)
        if (mEx[i] && mTag[i] == t) begin mEx[i] = 1'b0; mTag[i] = '0; end
    end
    @(negedge clk);
    chk(respValid == NP'(1 << p), "R10", 32'(respValid), 32'(1 << p));
    chk(respPass == (expPass ? NP'(1 << p) : NP'(0)), req, 32'(respPass),
        expPass ? 32'(1 << p) : 32'd0);
    reqValid[p] = 1'b0;
  endtask

  task automatic setDet(input int p, input bit v);
    @(negedge clk);
    detach[p] = v;
    mDet[p] = v;
    if (v) begin mEx[p] = 1'b0; mTag[p] = '0; end
  endtask

  // Exposes whether port p still holds a reservation on a
  task automatic probe(input int p, input logic [AW-1:0] a, input bit expPass, input string req);
    logic modelPass;
    modelPass = mEx[p] && (mTag[p] == (a & MASK)) && !mDet[p];
    chk(modelPass == expPass, req, 32'(modelPass), 32'(expPass));
    doOp(p, 3, a, req);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin mEx[i] = 0; mTag[i] = '0; mDet[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk(respValid == '0, "R1", 32'(respValid), 0);
    chk(reqGrant == '0, "R1", 32'(reqGrant), 0);
    for (int p = 0; p < NP; p++) doOp(p, 3, 32'h0, "R1");

    // R2: reservation covers the whole 8-byte granule
    doOp(0, 1, 32'h0000_1003, "R2");
    probe(0, 32'h0000_1007, 1'b1, "R2");
    probe(0, 32'h0000_1000, 1'b0, "R4");   // requester open after pass

    // R10: a read leaves the reservation intact
    doOp(1, 1, 32'h0000_2000, "R10");
    doOp(1, 0, 32'h0000_2000, "R10");
    probe(1, 32'h0000_2004, 1'b1, "R10");

    // Pair sweep: R4, R5 over every ordered pair, same or different granule
    for (int a = 0; a < NP; a++)
      for (int b = 0; b < NP; b++)
        for (int same = 0; same < 2; same++) begin
          if (a != b) begin
            logic [AW-1:0] xa, xb;
            xa = 32'h0000_4000 + 32'(a * 64);
            xb = same ? xa + 32'd5 : xa + 32'd8;
            doOp(a, 1, xa, "R2");
            doOp(b, 1, xb, "R2");
            probe(a, xa, 1'b1, "R4");
            probe(b, xb, same == 0, "R5");
          end
        end

    // R3: plain store by another port and by the requester itself
    for (int a = 0; a < NP; a++) begin
      doOp(a, 1, 32'h0000_5010, "R2");
      doOp((a + 1) % NP, 1, 32'h0000_5018, "R2");
      doOp((a + 2) % NP, 2, 32'h0000_5016, "R3");
      probe((a + 1) % NP, 32'h0000_5018, 1'b1, "R3");
      probe(a, 32'h0000_5010, 1'b0, "R3");
      doOp(a, 1, 32'h0000_5020, "R2");
      doOp(a, 2, 32'h0000_5021, "R3");
      probe(a, 32'h0000_5020, 1'b0, "R3");
    end

    // R6: failing store-exclusive from an open port leaves others alone
    doOp(2, 1, 32'h0000_6000, "R2");
    doOp(3, 3, 32'h0000_6000, "R6");
    probe(2, 32'h0000_6000, 1'b1, "R6");

    // R7: mismatched tag fails and keeps the requester's reservation
    doOp(1, 1, 32'h0000_7000, "R2");
    doOp(2, 1, 32'h0000_7008, "R2");
    doOp(1, 3, 32'h0000_7008, "R7");
    probe(1, 32'h0000_7000, 1'b1, "R7");
    probe(2, 32'h0000_7008, 1'b1, "R7");

    // R8: detach
    doOp(3, 1, 32'h0000_8000, "R2");
    setDet(3, 1'b1);
    doOp(3, 1, 32'h0000_8000, "R8");
    doOp(3, 3, 32'h0000_8000, "R8");
    setDet(3, 1'b0);
    probe(3, 32'h0000_8000, 1'b0, "R8");

    // R9: simultaneous requests served lowest index first
    @(negedge clk);
    reqOp = '0;
    reqValid = 4'b1110;
    for (int k = 1; k < NP; k++) begin
      #1;
      chk(reqGrant == NP'(1 << k), "R9", 32'(reqGrant), 32'(1 << k));
      @(negedge clk);
      chk(respValid == NP'(1 << k), "R10", 32'(respValid), 32'(1 << k));
      reqValid[k] = 1'b0;
    end
    @(negedge clk);

    // Random sweep against the model
    for (int n = 0; n < 3000; n++) begin
      int p, op;
      logic [AW-1:0] ad;
      p  = $urandom_range(NP - 1);
      op = $urandom_range(3);
      ad = 32'h0000_9000 + 32'($urandom_range(3) * 8) + 32'($urandom_range(7));
      if ($urandom_range(31) == 0) setDet(p, !mDet[p]);
      doOp(p, op, ad, "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule